// File: doc/BRIEF.md
# ATA Taskfile Write Sequencer

This block sits between a host controller and a PIO cycle engine on a parallel ATA port. It turns a high-level request into an ordered series of single register accesses. The request is one of four kinds: load a taskfile, read back the high-order address bytes, probe for a device, or select a device. It hands one access at a time to the engine and waits for the engine's completion pulse before it issues the next.

For a taskfile load, the device control register is rewritten only when its value differs from the value last sent. The sequencer keeps that value internally. For 48-bit addressing, the high-order copies of the five address-group registers go out ahead of the current copies. The probe writes an alternating 0x55/0xAA pattern into two registers and reads them back. A device is reported present only when the pattern survives.

A single `start` input launches a sequence. `done` pulses once the final access has completed, including when the sequence issued no access at all.

Top module: `tf_load_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid` and `present` are low. No control value is remembered, so the first load always writes the control register.
- R2: Register addresses are 4 bits: feature 0x1, count 0x2, LBA low 0x3, LBA mid 0x4, LBA high 0x5, device 0x6, control 0xE. In a load, control (`ctl_in`) is written first, and only if no value is remembered or it differs from the remembered one. A load or a high-order readback then remembers `ctl_in`.
- R3: When `addr_valid` and `lba48` are both set, a load next writes `hi_in` bytes 0..4 to registers 0x1..0x5 in that order. Byte k is bits [8k+7:8k].
- R4: When `addr_valid` is set, a load then writes `lo_in` bytes 0..4 to registers 0x1..0x5 in that order.
- R5: When `dev_valid` is set, a load writes `dev_in` to register 0x6 as its last access.
- R6: Only one access is outstanding at a time. `req_valid`, `req_addr` and `req_wdata` hold until `eng_done`, and `req_valid` drops in the cycle after `eng_done`.
- R7: `done` is a one-cycle pulse in the cycle after the final access completes, or after the step scan when no access is needed. `busy` is low when `done` is high.
- R8: A high-order readback (op 1) writes control as `ctl_in` | 0x80, reads registers 0x1..0x5 in order, then writes control as `ctl_in`. The byte read from register k+1 appears on `rd_bytes` byte k.
- R9: A probe (op 2) first selects the device as in R10. It then writes count=0x55, LBA low=0xAA, count=0xAA, LBA low=0x55, count=0x55, LBA low=0xAA, and reads count and then LBA low. `present` is set only if these read 0x55 and 0xAA. `present` changes only when a probe ends.
- R10: A select (op 3) writes register 0x6 with 0xA0, or with 0xB0 when `dev_sel` is 1.
- R11: A `start` while `busy` is high is ignored and adds no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sequence (ignored while busy) |
| op | input | 2 | 0 load, 1 high-order readback, 2 probe, 3 select |
| ctl_in | input | 8 | Device control value |
| lo_in | input | 40 | Current feature/count/LBA low/mid/high, byte 0 first |
| hi_in | input | 40 | High-order copies, same byte order |
| dev_in | input | 8 | Device register value for a load |
| addr_valid | input | 1 | Address-group registers are to be loaded |
| lba48 | input | 1 | Load high-order copies too |
| dev_valid | input | 1 | Device register is to be loaded |
| dev_sel | input | 1 | Device number for select and probe |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| present | output | 1 | Result of the last probe |
| rd_bytes | output | 40 | Last byte read from each register 0x1..0x5 |
| req_valid | output | 1 | Access request to the PIO engine |
| req_write | output | 1 | 1 write, 0 read |
| req_addr | output | 4 | Register address of the access |
| req_wdata | output | 8 | Write data |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata | input | 8 | Read data, valid with `eng_done` |

## Verification
The bench targets the control-change shortcut with repeated, changed and freshly reset control values. A design that compares wrongly writes control twice or never, and one that forgets the readback update adds a spurious control write to the following load. It mixes the address and device flags, including a load with nothing to write. A flawed step scan then hangs, misses the `done` pulse or swaps the high-order and current bytes. The probe runs against a device model that stores registers and against an absent device that reads 0xFF, which separates a correct pattern check from one that always reports present. A second `start` issued mid-sequence exposes a design that restarts or queues work while busy.

// File: rtl/tf_seq_pkg.sv
package tf_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_HOBRD = 2'd1,
    OP_PROBE = 2'd2,
    OP_SEL   = 2'd3
  } tf_op_e;

  localparam logic [ADDR_W-1:0] RA_COUNT = 4'h2;
  localparam logic [ADDR_W-1:0] RA_LBAL  = 4'h3;
  localparam logic [ADDR_W-1:0] RA_DEV   = 4'h6;
  localparam logic [ADDR_W-1:0] RA_CTL   = 4'hE;

  typedef struct packed {
    logic              en;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } step_t;
endpackage

// File: rtl/tf_step_decode.sv
module tf_step_decode
  import tf_seq_pkg::*;
#(
  parameter int          NB       = 5,
  parameter int          SW       = 4,
  parameter logic [7:0]  PAT_A    = 8'h55,
  parameter logic [7:0]  PAT_B    = 8'hAA,
  parameter logic [7:0]  HOB_MASK = 8'h80,
  parameter logic [7:0]  DEV_BASE = 8'hA0,
  parameter logic [7:0]  DEV1_BIT = 8'h10
) (
  input  tf_op_e               op,
  input  logic [SW-1:0]        idx,
  input  logic [BYTE_W-1:0]    ctl,
  input  logic [NB*BYTE_W-1:0] lo,
  input  logic [NB*BYTE_W-1:0] hi,
  input  logic [BYTE_W-1:0]    dev,
  input  logic                 addr_v,
  input  logic                 lba48,
  input  logic                 dev_v,
  input  logic                 dev_sel,
  input  logic                 ctl_diff,
  output step_t                st,
  output logic [SW-1:0]        last
);
  localparam int PROBE_WR = 6;
  localparam int PROBE_LAST = PROBE_WR + 2;

  logic [BYTE_W-1:0] sel_byte;
  assign sel_byte = DEV_BASE | (dev_sel ? DEV1_BIT : 8'h00);

  always_comb begin
    int i;
    i    = int'(idx);
    st   = '0;
    last = '0;
    unique case (op)
      OP_LOAD: begin
        last = SW'(2*NB + 1);
        st.wr = 1'b1;
        if (i == 0) begin
          st.en = ctl_diff; st.addr = RA_CTL; st.data = ctl;
        end else if (i <= NB) begin
          st.en = addr_v & lba48; st.addr = ADDR_W'(i);
          st.data = hi[BYTE_W*(i-1) +: BYTE_W];
        end else if (i <= 2*NB) begin
          st.en = addr_v; st.addr = ADDR_W'(i - NB);
          st.data = lo[BYTE_W*(i-NB-1) +: BYTE_W];
        end else begin
          st.en = dev_v; st.addr = RA_DEV; st.data = dev;
        end
      end
      OP_HOBRD: begin
        last  = SW'(NB + 1);
        st.en = 1'b1;
        if (i == 0) begin
          st.wr = 1'b1; st.addr = RA_CTL; st.data = ctl | HOB_MASK;
        end else if (i <= NB) begin
          st.wr = 1'b0; st.addr = ADDR_W'(i);
        end else begin
          st.wr = 1'b1; st.addr = RA_CTL; st.data = ctl;
        end
      end
      OP_PROBE: begin
        last  = SW'(PROBE_LAST);
        st.en = 1'b1;
        if (i == 0) begin
          st.wr = 1'b1; st.addr = RA_DEV; st.data = sel_byte;
        end else if (i <= PROBE_WR) begin
          st.wr   = 1'b1;
          st.addr = (i % 2 == 1) ? RA_COUNT : RA_LBAL;
          st.data = (i == 1 || i == 4 || i == 5) ? PAT_A : PAT_B;
        end else if (i == PROBE_WR + 1) begin
          st.wr = 1'b0; st.addr = RA_COUNT;
        end else begin
          st.wr = 1'b0; st.addr = RA_LBAL;
        end
      end
      OP_SEL: begin
        st.en = 1'b1; st.wr = 1'b1; st.addr = RA_DEV; st.data = sel_byte;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tf_ctl_track.sv
module tf_ctl_track
  import tf_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [BYTE_W-1:0] upd_val,
  input  logic [BYTE_W-1:0] cmp_val,
  output logic              differs
);
  logic [BYTE_W-1:0] last_q;
  logic              known_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      known_q <= 1'b0;
    end else if (upd) begin
      last_q  <= upd_val;
      known_q <= 1'b1;
    end
  end

  assign differs = !known_q || (last_q != cmp_val);

  a_r2_remembered: assert property (@(posedge clk) disable iff (rst)
    upd |=> (last_q == $past(upd_val)) && known_q);
endmodule

// File: rtl/tf_rd_capture.sv
module tf_rd_capture
  import tf_seq_pkg::*;
#(
  parameter int NB = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_en,
  input  logic [ADDR_W-1:0]    cap_addr,
  input  logic [BYTE_W-1:0]    cap_data,
  output logic [NB*BYTE_W-1:0] rd_bytes
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        rd_bytes[g*BYTE_W +: BYTE_W] <= '0;
      else if (cap_en && cap_addr == ADDR_W'(g + 1))
        rd_bytes[g*BYTE_W +: BYTE_W] <= cap_data;
    end
  end
endmodule

// File: rtl/tf_load_seq.sv
module tf_load_seq
  import tf_seq_pkg::*;
#(
  parameter int         NB       = 5,
  parameter logic [7:0] PAT_A    = 8'h55,
  parameter logic [7:0] PAT_B    = 8'hAA,
  parameter logic [7:0] HOB_MASK = 8'h80,
  parameter logic [7:0] DEV_BASE = 8'hA0,
  parameter logic [7:0] DEV1_BIT = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [1:0]           op,
  input  logic [BYTE_W-1:0]    ctl_in,
  input  logic [NB*BYTE_W-1:0] lo_in,
  input  logic [NB*BYTE_W-1:0] hi_in,
  input  logic [BYTE_W-1:0]    dev_in,
  input  logic                 addr_valid,
  input  logic                 lba48,
  input  logic                 dev_valid,
  input  logic                 dev_sel,
  output logic                 busy,
  output logic                 done,
  output logic                 present,
  output logic [NB*BYTE_W-1:0] rd_bytes,
  output logic                 req_valid,
  output logic                 req_write,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [BYTE_W-1:0]    req_wdata,
  input  logic                 eng_done,
  input  logic [BYTE_W-1:0]    eng_rdata
);
  localparam int SW = $clog2(2*NB + 3);
  localparam int CNT_LO = BYTE_W * (int'(RA_COUNT) - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  state_e                state_q;
  tf_op_e                op_q;
  logic [SW-1:0]         idx_q;
  logic [BYTE_W-1:0]     ctl_q, dev_q;
  logic [NB*BYTE_W-1:0]  lo_q, hi_q;
  logic                  av_q, l48_q, dv_q, ds_q;

  step_t                 st;
  logic [SW-1:0]         last_idx;
  logic                  ctl_diff, fin, at_last, cap_en;

  tf_step_decode #(
    .NB(NB), .SW(SW), .PAT_A(PAT_A), .PAT_B(PAT_B),
    .HOB_MASK(HOB_MASK), .DEV_BASE(DEV_BASE), .DEV1_BIT(DEV1_BIT)
  ) u_dec (
    .op(op_q), .idx(idx_q), .ctl(ctl_q), .lo(lo_q), .hi(hi_q), .dev(dev_q),
    .addr_v(av_q), .lba48(l48_q), .dev_v(dv_q), .dev_sel(ds_q),
    .ctl_diff(ctl_diff), .st(st), .last(last_idx)
  );

  tf_ctl_track u_ctl (
    .clk(clk), .rst(rst),
    .upd(fin && (op_q == OP_LOAD || op_q == OP_HOBRD)),
    .upd_val(ctl_q), .cmp_val(ctl_q), .differs(ctl_diff)
  );

  assign cap_en = (state_q == S_WAIT) && eng_done && !req_write;

  tf_rd_capture #(.NB(NB)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_addr(req_addr),
    .cap_data(eng_rdata), .rd_bytes(rd_bytes)
  );

  assign at_last = (idx_q == last_idx);
  assign fin = ((state_q == S_ISSUE) && !st.en && at_last) ||
               ((state_q == S_WAIT) && eng_done && at_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      op_q      <= OP_LOAD;
      idx_q     <= '0;
      {ctl_q, dev_q, lo_q, hi_q} <= '0;
      {av_q, l48_q, dv_q, ds_q}  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      present   <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      done <= fin;
      unique case (state_q)
        S_IDLE: if (start) begin
          op_q  <= tf_op_e'(op);
          ctl_q <= ctl_in;  dev_q <= dev_in;
          lo_q  <= lo_in;   hi_q  <= hi_in;
          av_q  <= addr_valid; l48_q <= lba48;
          dv_q  <= dev_valid;  ds_q  <= dev_sel;
          idx_q   <= '0;
          busy    <= 1'b1;
          state_q <= S_ISSUE;
        end
        S_ISSUE: begin
          if (st.en) begin
            req_valid <= 1'b1;
            req_write <= st.wr;
            req_addr  <= st.addr;
            req_wdata <= st.data;
            state_q   <= S_WAIT;
          end else if (fin) begin
            busy    <= 1'b0;
            state_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_WAIT: if (eng_done) begin
          req_valid <= 1'b0;
          if (fin) begin
            busy    <= 1'b0;
            state_q <= S_IDLE;
            if (op_q == OP_PROBE)
              present <= (rd_bytes[CNT_LO +: BYTE_W] == PAT_A) && (eng_rdata == PAT_B);
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_ISSUE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R6: one outstanding access, held stable until completion
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !eng_done) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)));
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    (req_valid && eng_done) |=> !req_valid);
  // R7: done is a single-cycle pulse at the end of a sequence
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R11: no access outside a running sequence
  a_r11_no_req_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);
  // R9: presence only changes as a probe ends
  a_r9_present_at_end: assert property (@(posedge clk) disable iff (rst)
    !$stable(present) |-> done);
endmodule

// File: tb/tf_load_seq_bench.sv
`timescale 1ns/1ps
module tf_load_seq_bench;
  import tf_seq_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1, start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [7:0]  ctl_in = '0, dev_in = '0;
  logic [39:0] lo_in = '0, hi_in = '0;
  logic        addr_valid = 0, lba48 = 0, dev_valid = 0, dev_sel = 0;
  logic        busy, done, present, req_valid, req_write;
  logic [39:0] rd_bytes;
  logic [3:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        eng_done = 1'b0;
  logic [7:0]  eng_rdata = '0;

  tf_load_seq u_tf_load_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .ctl_in(ctl_in),
    .lo_in(lo_in), .hi_in(hi_in), .dev_in(dev_in), .addr_valid(addr_valid),
    .lba48(lba48), .dev_valid(dev_valid), .dev_sel(dev_sel), .busy(busy),
    .done(done), .present(present), .rd_bytes(rd_bytes), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [12:0] expq[$];

  // device register model
  logic [7:0] dcur [0:7];
  logic [7:0] dprev[0:7];
  logic [7:0] dctl = 8'h00;
  bit dev_here = 1'b1;
  // bench's own view of the remembered control value
  logic [7:0] m_ctl = '0;
  bit m_vld = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [3:0] a, input logic [7:0] d);
    expq.push_back({wr, a, d});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin dcur[k] = 8'h01; dprev[k] = 8'h01; end
  end

  // engine responder and scoreboard monitor
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      else if (req_valid) begin
        if (lat < 2) lat++;
        else begin
          int a;
          lat = 0;
          a = int'(req_addr);
          if (expq.size() == 0)
            chk(1'b0, cur_req, "unexpected access", {req_write, req_addr, req_wdata}, 0);
          else begin
            logic [12:0] e;
            e = expq.pop_front();
            chk(req_write == e[12] && req_addr == e[11:8] && (!e[12] || req_wdata == e[7:0]),
                cur_req, "access", {req_write, req_addr, req_wdata}, e);
          end
          if (req_write) begin
            if (req_addr == RA_CTL) dctl = req_wdata;
            else begin dprev[a[2:0]] = dcur[a[2:0]]; dcur[a[2:0]] = req_wdata; end
          end else
            eng_rdata = !dev_here ? 8'hFF : (dctl[7] ? dprev[a[2:0]] : dcur[a[2:0]]);
          eng_done = 1'b1;
        end
      end
    end
  end

  task automatic expect_load();
    if (!m_vld || m_ctl != ctl_in) push(1, RA_CTL, ctl_in);
    m_ctl = ctl_in; m_vld = 1'b1;
    if (addr_valid && lba48)
      for (int k = 0; k < 5; k++) push(1, 4'(k + 1), hi_in[8*k +: 8]);
    if (addr_valid)
      for (int k = 0; k < 5; k++) push(1, 4'(k + 1), lo_in[8*k +: 8]);
    if (dev_valid) push(1, RA_DEV, dev_in);
  endtask

  task automatic run(input logic [1:0] o, input bit extra);
    int t;
    op = o;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (3) @(negedge clk);
      op = 2'd2; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk(done == 1'b1, cur_req, "done pulse seen", done, 1);
    chk(expq.size() == 0, cur_req, "missing accesses", expq.size(), 0);
    expq.delete();
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done one cycle, idle", {done, busy}, 0);
  endtask

  initial begin
    logic [39:0] exp_hob;
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [39:0] exp_hob;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, req_valid, present} == 4'b0, "R1", "reset outputs",
        {busy, done, req_valid, present}, 0);

    // first load after reset: control always written, then hi, lo, device
    cur_req = "R1 R3 R4 R5";
    ctl_in = 8'h08; hi_in = 40'h2524232221; lo_in = 40'h1514131211; dev_in = 8'hE0;
    addr_valid = 1; lba48 = 1; dev_valid = 1;
    expect_load(); run(2'd0, 0);

    cur_req = "R2 R4";
    lo_in = 40'h3534333231; lba48 = 0; dev_valid = 0;
    expect_load(); run(2'd0, 0);

    cur_req = "R2 R5";
    ctl_in = 8'h0A; addr_valid = 0; dev_valid = 1; dev_in = 8'hF0;
    expect_load(); run(2'd0, 0);

    cur_req = "R7";
    dev_valid = 0;
    expect_load(); run(2'd0, 0);

    // high-order readback
    cur_req = "R8";
    exp_hob = {dprev[5], dprev[4], dprev[3], dprev[2], dprev[1]};
    push(1, RA_CTL, 8'h8A);
    for (int k = 1; k <= 5; k++) push(0, 4'(k), 8'h00);
    push(1, RA_CTL, 8'h0A);
    m_ctl = 8'h0A; m_vld = 1'b1;
    run(2'd1, 0);
    chk(rd_bytes == exp_hob, "R8", "high-order bytes", rd_bytes, exp_hob);

    cur_req = "R2 R3 R4";
    addr_valid = 1; lba48 = 1; hi_in = 40'h4544434241; lo_in = 40'h5554535251;
    expect_load(); run(2'd0, 0);

    cur_req = "R10";
    dev_sel = 1; push(1, RA_DEV, 8'hB0); run(2'd3, 0);
    dev_sel = 0; push(1, RA_DEV, 8'hA0); run(2'd3, 0);

    cur_req = "R9";
    push(1, RA_DEV, 8'hA0);
    push(1, RA_COUNT, 8'h55); push(1, RA_LBAL, 8'hAA);
    push(1, RA_COUNT, 8'hAA); push(1, RA_LBAL, 8'h55);
    push(1, RA_COUNT, 8'h55); push(1, RA_LBAL, 8'hAA);
    push(0, RA_COUNT, 0); push(0, RA_LBAL, 0);
    run(2'd2, 0);
    chk(present == 1'b1, "R9", "present device", present, 1);

    dev_here = 1'b0;
    push(1, RA_DEV, 8'hA0);
    push(1, RA_COUNT, 8'h55); push(1, RA_LBAL, 8'hAA);
    push(1, RA_COUNT, 8'hAA); push(1, RA_LBAL, 8'h55);
    push(1, RA_COUNT, 8'h55); push(1, RA_LBAL, 8'hAA);
    push(0, RA_COUNT, 0); push(0, RA_LBAL, 0);
    run(2'd2, 0);
    chk(present == 1'b0, "R9", "absent device", present, 0);

    // second start while busy is ignored
    dev_here = 1'b1;
    cur_req = "R11";
    ctl_in = 8'h0C; addr_valid = 1; lba48 = 0; dev_valid = 0;
    expect_load(); run(2'd0, 1);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (req_valid || busy || done) quiet = 1'b0;
      end
      chk(quiet, "R11", "no work after ignored start", quiet, 1);
    end
    chk(present == 1'b0, "R9", "present unchanged by load", present, 0);

    summary();
    $finish;
  end
endmodule